// File: doc/BRIEF.md
# Early-Terminating Slice Multiplier

This block is a sequential multiplier that gives the low 32 bits of the product of two 32-bit operands. In each working cycle it multiplies the whole multiplicand by one 8-bit piece of the multiplier. It works from the least significant piece upward. When every multiplier bit above the pieces already consumed is a copy of one value (all zeros or all ones), it stops. Small multipliers, positive or negative, therefore finish sooner than large ones. The latency ranges from 2 to 5 cycles.

A requester holds `start_i` high with both operands. The block takes them in the first idle cycle and registers them, so the requester may change its operand lines straight after that. `busy_o` is high while slices are being processed. `done_o` is a one-cycle pulse that marks the cycle in which `product_o` first holds the final result. The low 32 bits of a product are the same for signed and unsigned operands, so there is no mode input.

Top module: `slice_mul_top`

## Requirements
- R1: At the done pulse, `product_o` equals (op_a × op_b) mod 2^32 for the operands presented with the accepted start. The result is identical whether the operands are read as signed or as unsigned.
- R2: Latency N counts the cycle in which the start is accepted as cycle 1 and the done cycle as cycle N, so `done_o` rises N−1 rising edges after the edge that samples the start. N is 2 when multiplier bits 31..8 are all zero or all one.
- R3: N is 3 when multiplier bits 31..16 are all zero or all one and the R2 condition does not hold.
- R4: N is 4 when multiplier bits 31..24 are all zero or all one and neither shorter condition holds.
- R5: N is 5 for every other multiplier value. The multiplicand value never changes N.
- R6: While `busy_o` is high, `start_i` is ignored. The operands are registered on the accepted start, so changes on `op_a_i`, `op_b_i` or `start_i` during an operation do not change that operation's result or latency.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle. `product_o` then stays unchanged until the next accepted start. A start may be accepted in the done cycle itself.
- R8: An active-low `rst_n` asynchronously forces `busy_o`, `done_o` and `product_o` to zero. This applies even in the middle of an operation.
- R9: A multiplier that is a 16-bit value, either zero-extended or sign-extended to 32 bits, completes in 2 or 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a multiply; accepted when not busy |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier; its upper bits set the latency |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 32 | Low 32 bits of the product |

## Verification
The bench sweeps every value of the deciding multiplier byte, for each latency class and both sign fills. It checks each product and each cycle count against arithmetic computed in the bench.

Multipliers such as 0xFFFFFF05 and 0xFFFF7F00 target the all-ones early stop. A design that drops the negative weight of the discarded upper bits returns a badly wrong product there. The class boundaries, for example 0x000000FF against 0x00000100, catch an off-by-one slice count, which shows up as a cycle count one too high or too low.

Start pulses and operand changes during busy cycles would corrupt the result or restart the count if the inputs were not registered. A reset in the middle of an operation and the hold check after done expose a result that drifts or a done that lasts two cycles.

// File: rtl/slice_mul_pkg.sv
package slice_mul_pkg;

  typedef enum logic {
    SM_IDLE = 1'b0,
    SM_RUN  = 1'b1
  } sm_state_e;

endpackage

// File: rtl/slice_mul_class.sv
// Picks the number of slices to process from the multiplier's upper bits,
// and whether the discarded upper field has negative weight.
module slice_mul_class #(
  parameter int W  = 32,
  parameter int S  = 8,
  parameter int N  = W / S,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [W-1:0]  mult_i,
  output logic [CW-1:0] nslice_o,
  output logic          upper_neg_o
);

  logic [N-1:0] uniform;

  assign uniform[0] = 1'b0;

  generate
    for (genvar k = 1; k < N; k++) begin : g_field
      logic [W-S*k-1:0] field;
      assign field      = mult_i[W-1:S*k];
      assign uniform[k] = (&field) | ~(|field);
    end
  endgenerate

  always_comb begin
    nslice_o    = CW'(N);
    upper_neg_o = 1'b0;
    for (int k = N - 1; k >= 1; k--) begin
      if (uniform[k]) begin
        nslice_o    = CW'(k);
        upper_neg_o = mult_i[W-1];
      end
    end
  end

  always_comb begin
    p_class_range_r5: assert (nslice_o >= CW'(1) && nslice_o <= CW'(N))
      else $error("slice count out of range");
  end

endmodule

// File: rtl/slice_mul_pp.sv
// Multiplicand times one unsigned slice, with an optional negative weight
// of -2^S applied on the final slice.
module slice_mul_pp #(
  parameter int W = 32,
  parameter int S = 8
) (
  input  logic [W-1:0] mcand_i,
  input  logic [S-1:0] digit_i,
  input  logic         neg_top_i,
  output logic [W-1:0] pp_o
);

  logic [W-1:0] rows [S];

  generate
    for (genvar j = 0; j < S; j++) begin : g_row
      assign rows[j] = digit_i[j] ? (mcand_i << j) : '0;
    end
  endgenerate

  always_comb begin
    pp_o = '0;
    for (int j = 0; j < S; j++) begin
      pp_o = pp_o + rows[j];
    end
    if (neg_top_i) begin
      pp_o = pp_o - (mcand_i << S);
    end
  end

endmodule

// File: rtl/slice_mul_ctrl.sv
module slice_mul_ctrl
  import slice_mul_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] nslice_i,
  output logic          accept_o,
  output logic          step_o,
  output logic          last_o,
  output logic          busy_o,
  output logic          done_o
);

  sm_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  assign accept_o = start_i && (state_q == SM_IDLE);
  assign step_o   = (state_q == SM_RUN);
  assign last_o   = step_o && (cnt_q == '0);
  assign busy_o   = step_o;
  assign done_o   = done_q;
  assign cnt_en   = accept_o || step_o;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      SM_IDLE: begin
        if (accept_o) begin
          state_d = SM_RUN;
          cnt_d   = nslice_i - CW'(1);
        end
      end
      SM_RUN: begin
        if (last_o) begin
          state_d = SM_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = SM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SM_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done longer than one cycle");

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_o)
    else $error("busy during done");

  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !last_o) |=> (step_o && cnt_q == $past(cnt_q) - CW'(1)))
    else $error("operation disturbed while busy");

  p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(step_o))
    else $error("done without a run cycle");

endmodule

// File: rtl/slice_mul_top.sv
module slice_mul_top
  import slice_mul_pkg::*;
#(
  parameter int W = 32,
  parameter int S = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] product_o
);

  localparam int N  = W / S;
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] nslice;
  logic          upper_neg;
  logic          accept, step, last;
  logic [W-1:0]  a_sh_q, a_sh_d;
  logic [W-1:0]  b_sh_q, b_sh_d;
  logic          neg_q;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  pp;
  logic          dp_en;

  slice_mul_class #(.W(W), .S(S), .N(N), .CW(CW)) u_class (
    .mult_i      (op_b_i),
    .nslice_o    (nslice),
    .upper_neg_o (upper_neg)
  );

  slice_mul_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .nslice_i (nslice),
    .accept_o (accept),
    .step_o   (step),
    .last_o   (last),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  slice_mul_pp #(.W(W), .S(S)) u_pp (
    .mcand_i   (a_sh_q),
    .digit_i   (b_sh_q[S-1:0]),
    .neg_top_i (last && neg_q),
    .pp_o      (pp)
  );

  assign dp_en = accept || step;

  always_comb begin
    a_sh_d = a_sh_q;
    b_sh_d = b_sh_q;
    acc_d  = acc_q;
    if (accept) begin
      a_sh_d = op_a_i;
      b_sh_d = op_b_i;
      acc_d  = '0;
    end else if (step) begin
      a_sh_d = a_sh_q << S;
      b_sh_d = b_sh_q >> S;
      acc_d  = acc_q + pp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh_q <= '0;
      b_sh_q <= '0;
      acc_q  <= '0;
    end else if (dp_en) begin
      a_sh_q <= a_sh_d;
      b_sh_q <= b_sh_d;
      acc_q  <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
    end else if (accept) begin
      neg_q <= upper_neg;
    end
  end

  assign product_o = acc_q;

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o))
    else $error("result changed while idle");

  p_accept_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o)
    else $error("accepted start did not begin an operation");

endmodule

// File: tb/slice_mul_top_bench.sv
`timescale 1ns/1ps
module slice_mul_top_bench;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] op_a_i, op_b_i;
  logic        busy_o, done_o;
  logic [31:0] product_o;

  int checks;
  int failures;
  logic [31:0] seed;
  bit finished;

  slice_mul_top u_slice_mul_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic int exp_cycles(input logic [31:0] b);
    for (int k = 1; k <= 3; k++) begin
      logic [31:0] up;
      up = b >> (8 * k);
      if (up == 32'd0 || up == (32'hFFFF_FFFF >> (8 * k))) return k + 1;
    end
    return 5;
  endfunction

  function automatic string cls_tag(input int n);
    case (n)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        output int cyc, output logic [31:0] prod);
    @(negedge clk);
    start_i = 1'b1;
    op_a_i  = a;
    op_b_i  = b;
    @(negedge clk);
    start_i = 1'b0;
    op_a_i  = next_rand();
    op_b_i  = next_rand();
    cyc = 1;
    prod = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cyc++;
      if (done_o) begin
        start_i = 1'b0;
        prod = product_o;
        break;
      end
      // R6: garbage requests while busy must be ignored
      start_i = 1'b1;
      op_a_i  = next_rand();
      op_b_i  = next_rand();
    end
    start_i = 1'b0;
  endtask

  task automatic full_check(input logic [31:0] a, input logic [31:0] b);
    int cyc;
    int ec;
    logic [31:0] prod;
    logic [31:0] exp;
    exp = a * b;
    ec = exp_cycles(b);
    run_op(a, b, cyc, prod);
    check(prod == exp, "R1 product", prod, exp);
    check(cyc == ec, cls_tag(ec), 32'(cyc), 32'(ec));
  endtask

  initial begin
    #(8.0 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [31:0] prod;
    logic [31:0] b;
    logic [7:0]  lo;
    checks = 0;
    failures = 0;
    finished = 0;
    seed = 32'h1234_5678;
    rst_n = 1'b0;
    start_i = 1'b0;
    op_a_i = '0;
    op_b_i = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(busy_o == 1'b0, "R8 busy", 32'(busy_o), 0);
    check(done_o == 1'b0, "R8 done", 32'(done_o), 0);
    check(product_o == 0, "R8 product", product_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed class boundaries and sign-fill cases (R1..R5)
    full_check(32'h1234_5678, 32'h0000_0000);
    full_check(32'h1234_5678, 32'hFFFF_FFFF);
    full_check(32'h8765_4321, 32'h0000_00FF);
    full_check(32'h8765_4321, 32'h0000_0100);
    full_check(32'hDEAD_BEEF, 32'hFFFF_FF05);
    full_check(32'hDEAD_BEEF, 32'hFFFF_FF7F);
    full_check(32'h0F0F_0F0F, 32'hFFFF_7F00);
    full_check(32'h0F0F_0F0F, 32'h00FF_FFFF);
    full_check(32'h7FFF_FFFF, 32'h0100_0000);
    full_check(32'hFFFF_FFFF, 32'h8000_0000);
    full_check(32'h8000_0000, 32'h7FFF_FFFF);

    // R9: 16-bit multipliers, zero- and sign-extended
    for (int v = 0; v < 4; v++) begin
      logic [15:0] h;
      logic [31:0] ze, se;
      h  = (v == 0) ? 16'h8000 : (v == 1) ? 16'hFFFF : (v == 2) ? 16'h7FFF : 16'h0123;
      ze = {16'h0000, h};
      se = {{16{h[15]}}, h};
      run_op(32'h0000_ABCD, ze, cyc, prod);
      check(cyc == 2 || cyc == 3, "R9 zext", 32'(cyc), 3);
      check(prod == 32'h0000_ABCD * ze, "R9 zext product", prod, 32'h0000_ABCD * ze);
      run_op(32'hFFFF_8001, se, cyc, prod);
      check(cyc == 2 || cyc == 3, "R9 sext", 32'(cyc), 3);
      check(prod == 32'hFFFF_8001 * se, "R9 sext product", prod, 32'hFFFF_8001 * se);
    end

    // R7: pulse width and result hold while idle
    run_op(32'h0000_0003, 32'h0000_0007, cyc, prod);
    @(negedge clk);
    check(done_o == 1'b0, "R7 done width", 32'(done_o), 0);
    check(busy_o == 1'b0, "R7 idle busy", 32'(busy_o), 0);
    op_a_i = 32'hFFFF_FFFF;
    op_b_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check(product_o == 32'd21, "R7 hold", product_o, 32'd21);

    // R7: back-to-back start accepted in the done cycle
    @(negedge clk);
    start_i = 1'b1; op_a_i = 32'd5; op_b_i = 32'd6;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b1, "R7 first done", 32'(done_o), 1);
    start_i = 1'b1; op_a_i = 32'd9; op_b_i = 32'd11;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R7 accept in done cycle", 32'(busy_o), 1);
    @(negedge clk);
    check(done_o == 1'b1 && product_o == 32'd99, "R7 second result", product_o, 32'd99);

    // R8: reset in the middle of a long operation
    @(negedge clk);
    start_i = 1'b1; op_a_i = 32'h1357_9BDF; op_b_i = 32'h1234_5678;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy_o == 1'b0, "R8 mid busy", 32'(busy_o), 0);
    check(done_o == 1'b0, "R8 mid done", 32'(done_o), 0);
    check(product_o == 0, "R8 mid product", product_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    full_check(32'h1357_9BDF, 32'h1234_5678);

    // Sweep: every deciding byte for every class and sign fill (R1..R6)
    for (int k = 1; k <= 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        for (int l = 0; l < 256; l++) begin
          b  = next_rand();
          lo = 8'(l);
          if (k == 4) begin
            if (lo == 8'h00 || lo == 8'hFF) lo = lo ^ 8'h01;
          end else begin
            if (k > 1 && lo == (s ? 8'hFF : 8'h00)) lo = lo ^ 8'h01;
            b = (b & ~(32'hFFFF_FFFF << (8 * k))) |
                (s ? (32'hFFFF_FFFF << (8 * k)) : 32'h0);
          end
          b = (b & ~(32'hFF << (8 * (k - 1)))) | (32'(lo) << (8 * (k - 1)));
          full_check(next_rand(), b);
        end
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule